// File: doc/BRIEF.md
# Engine Execution Control Command Port

This block is the host-facing control port of a small processor engine. The host sees a handful of word-wide registers: a data word, an address word, a command/status word, a completed-instruction counter and a cycle profile counter. A single write to the command register runs one operation. The operation can start or halt the engine, single-step one instruction, flush the pipeline, zero the profile counter, or move one word between the data register and one of three storage spaces. The three spaces are instruction memory, data memory and a 32-entry execution-context register file.

To store a word, the host loads the data register, then the address register, then writes the command. To fetch a word, the host loads the address, writes the command and then reads the data register. A fetched value lands in the data register only after a fixed latency. The two data-register reads that directly follow the command therefore still show the old word, and the third read shows the fetched one. Instruction decode is not modelled. A step only waits a fixed number of cycles and then advances the counter.

Top module: `exec_cmd_port`

## Requirements
- R1: After synchronous reset the status word reads 0x4000_0000 (halted only), and the watch counter, profile counter, data register and address register all read zero.
- R2: Register select 0 is the data register and select 1 is the address register; both read back the last value the host wrote. Select 2 issues a command taken from write bits 7:0, and bits 31:8 are ignored. Select 3 is the watch counter, which the host can write. Select 4 is the profile counter, which is read-only. Selects 5 to 7 read zero.
- R3: Commands 0x11 (instruction memory), 0x13 (data memory) and 0x15 (context file) store the data register at the address register on the command edge. Address bits above each space's index width are ignored.
- R4: Commands 0x10, 0x12 and 0x14 fetch from the same three spaces. The data register takes the fetched word exactly two clock edges after the command edge. The two reads in the cycles before that still return the previous value.
- R5: Command 0x02 sets status bit 31 (running) and clears bit 30 (halted). Command 0x03 does the opposite.
- R6: Command 0x04 raises status bits 29 (flushed) and 23 (pipeline clean) for exactly the one cycle after the command edge.
- R7: Command 0x01, accepted only while halted and with no step in flight, increments the watch counter once, exactly three clock edges after the command. A step issued while running or while a step is in flight has no effect.
- R8: The profile counter increments on every edge at which the engine was running. Command 0x0C zeroes it, and the clear takes priority over the increment.
- R9: The context file holds valid entries only at addresses 0x00–0x02, 0x04–0x06, 0x08–0x0A, 0x0C–0x0E and 0x11. All entries reset to zero. A write to any other context address is dropped, and such an address reads zero.
- R10: Any other command code, including 0x16 and 0x17, changes no register, status bit or stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 3 | Host register select |
| bus_wr | input | 1 | Host write strobe for the selected register |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Selected register contents (combinational) |

## Verification
A wrong fetch pipeline shows up as a data-register value that is fresh one cycle too early or stale one cycle too late. The bench therefore samples all three reads after every fetch command. A miscounting step timer moves the watch increment off its third edge, or lets a second step through, and this is visible within four reads of the command. Corrupted run state shows in the status word on the very next cycle. It also shows in the profile counter, which drifts by one per cycle after the bad transition. A context-file hole that accepts writes returns a non-zero word on the third read of the following fetch.

// File: rtl/ecp_pkg.sv
`timescale 1ns/1ps
package ecp_pkg;

    localparam int DATA_W      = 32;
    localparam int CTX_ENTRIES = 32;
    localparam int CTX_IDX_W   = $clog2(CTX_ENTRIES);

    typedef enum logic [2:0] {
        SEL_DATA  = 3'd0,
        SEL_ADDR  = 3'd1,
        SEL_CMD   = 3'd2,
        SEL_WATCH = 3'd3,
        SEL_PROF  = 3'd4
    } sel_e;

    localparam logic [7:0] CODE_STEP     = 8'h01;
    localparam logic [7:0] CODE_START    = 8'h02;
    localparam logic [7:0] CODE_HALT     = 8'h03;
    localparam logic [7:0] CODE_FLUSH    = 8'h04;
    localparam logic [7:0] CODE_PROF_CLR = 8'h0C;
    localparam logic [4:0] CODE_XFER_HI  = 5'b00010;

    localparam int ST_RUN   = 31;
    localparam int ST_HALT  = 30;
    localparam int ST_FLUSH = 29;
    localparam int ST_CLEAN = 23;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_STEP,
        OP_START,
        OP_HALT,
        OP_FLUSH,
        OP_PROF_CLR,
        OP_FETCH,
        OP_STORE
    } op_e;

    typedef enum logic [1:0] {
        SP_INSTR = 2'd0,
        SP_DATA  = 2'd1,
        SP_CTX   = 2'd2,
        SP_BAD   = 2'd3
    } space_e;

    typedef struct packed {
        op_e    op;
        space_e sp;
    } req_t;

    function automatic logic ctx_addr_ok(input logic [CTX_IDX_W-1:0] a);
        if (a == 5'h11)
            return 1'b1;
        if (a[4])
            return 1'b0;
        return (a[1:0] != 2'b11);
    endfunction

    function automatic logic [DATA_W-1:0] status_word(input logic run,
                                                      input logic halted,
                                                      input logic flushed);
        logic [DATA_W-1:0] w;
        w           = '0;
        w[ST_RUN]   = run;
        w[ST_HALT]  = halted;
        w[ST_FLUSH] = flushed;
        w[ST_CLEAN] = flushed;
        return w;
    endfunction

endpackage

// File: rtl/ecp_decode.sv
`timescale 1ns/1ps
module ecp_decode
    import ecp_pkg::*;
(
    input  logic       strobe,
    input  logic [7:0] code,
    output req_t       req
);

    always_comb begin
        req.op = OP_NONE;
        req.sp = SP_INSTR;
        if (strobe) begin
            if (code[7:3] == CODE_XFER_HI && code[2:1] != 2'b11) begin
                req.sp = space_e'(code[2:1]);
                req.op = code[0] ? OP_STORE : OP_FETCH;
            end else begin
                case (code)
                    CODE_STEP:     req.op = OP_STEP;
                    CODE_START:    req.op = OP_START;
                    CODE_HALT:     req.op = OP_HALT;
                    CODE_FLUSH:    req.op = OP_FLUSH;
                    CODE_PROF_CLR: req.op = OP_PROF_CLR;
                    default:       req.op = OP_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/ecp_run_ctrl.sv
`timescale 1ns/1ps
module ecp_run_ctrl
    import ecp_pkg::*;
#(
    parameter int STEP_LAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic              watch_wr,
    input  logic [DATA_W-1:0] watch_wdata,
    output logic              running,
    output logic              halted,
    output logic              flushed,
    output logic [DATA_W-1:0] watch,
    output logic [DATA_W-1:0] profile
);

    localparam int SCW = $clog2(STEP_LAT + 1);

    logic [SCW-1:0] step_cnt;
    logic           step_take;
    logic           step_done;

    assign step_take = (op == OP_STEP) && !running && (step_cnt == '0);
    assign step_done = (step_cnt == SCW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            halted  <= 1'b1;
        end else if (op == OP_START) begin
            running <= 1'b1;
            halted  <= 1'b0;
        end else if (op == OP_HALT) begin
            running <= 1'b0;
            halted  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            flushed <= 1'b0;
        else
            flushed <= (op == OP_FLUSH);
    end

    always_ff @(posedge clk) begin
        if (rst)
            step_cnt <= '0;
        else if (step_take)
            step_cnt <= SCW'(STEP_LAT);
        else if (step_cnt != '0)
            step_cnt <= step_cnt - SCW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            watch <= '0;
        else if (watch_wr)
            watch <= watch_wdata;
        else if (step_done)
            watch <= watch + DATA_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            profile <= '0;
        else if (op == OP_PROF_CLR)
            profile <= '0;
        else if (running)
            profile <= profile + DATA_W'(1);
    end

    a_r5_run_rises_on_start: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> $past(op == OP_START));

    a_r6_flush_from_command: assert property (@(posedge clk) disable iff (rst)
        flushed |-> $past(op == OP_FLUSH));

    a_r7_watch_single_step: assert property (@(posedge clk) disable iff (rst)
        (watch != $past(watch)) && !$past(watch_wr) |-> watch == $past(watch) + 32'd1);

    a_r8_profile_frozen: assert property (@(posedge clk) disable iff (rst)
        !$past(running) && !$past(op == OP_PROF_CLR) |-> $stable(profile));

endmodule

// File: rtl/ecp_store.sv
`timescale 1ns/1ps
module ecp_store
    import ecp_pkg::*;
#(
    parameter int IMEM_DEPTH = 256,
    parameter int DMEM_DEPTH = 256,
    parameter int RD_LAT     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  req_t              req,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int IW   = $clog2(IMEM_DEPTH);
    localparam int DIW  = $clog2(DMEM_DEPTH);
    localparam int AW0  = (IW > DIW) ? IW : DIW;
    localparam int AW   = (AW0 > CTX_IDX_W) ? AW0 : CTX_IDX_W;
    localparam int NSTG = RD_LAT - 1;

    logic [DATA_W-1:0] imem  [IMEM_DEPTH];
    logic [DATA_W-1:0] dmem  [DMEM_DEPTH];
    logic [DATA_W-1:0] ctx_q [CTX_ENTRIES];

    logic               stg_v  [NSTG];
    space_e             stg_sp [NSTG];
    logic [AW-1:0]      stg_a  [NSTG];

    logic [IW-1:0]        i_idx;
    logic [DIW-1:0]       d_idx;
    logic [CTX_IDX_W-1:0] c_idx;

    assign i_idx = addr[IW-1:0];
    assign d_idx = addr[DIW-1:0];
    assign c_idx = addr[CTX_IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (req.op == OP_STORE && req.sp == SP_INSTR)
            imem[i_idx] <= wdata;
        if (req.op == OP_STORE && req.sp == SP_DATA)
            dmem[d_idx] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CTX_ENTRIES; i++)
                ctx_q[i] <= '0;
        end else if (req.op == OP_STORE && req.sp == SP_CTX && ctx_addr_ok(c_idx)) begin
            ctx_q[c_idx] <= wdata;
        end
    end

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)
                    stg_v[0] <= 1'b0;
                else
                    stg_v[0] <= (req.op == OP_FETCH);
                stg_sp[0] <= req.sp;
                stg_a[0]  <= addr;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)
                    stg_v[g] <= 1'b0;
                else
                    stg_v[g] <= stg_v[g-1];
                stg_sp[g] <= stg_sp[g-1];
                stg_a[g]  <= stg_a[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= stg_v[NSTG-1];
            if (stg_v[NSTG-1]) begin
                case (stg_sp[NSTG-1])
                    SP_INSTR: rd_data <= imem[stg_a[NSTG-1][IW-1:0]];
                    SP_DATA:  rd_data <= dmem[stg_a[NSTG-1][DIW-1:0]];
                    SP_CTX:   rd_data <= ctx_q[stg_a[NSTG-1][CTX_IDX_W-1:0]];
                    default:  rd_data <= '0;
                endcase
            end
        end
    end

    a_r9_holes_stay_zero: assert property (@(posedge clk) disable iff (rst)
        ctx_q[3] == '0 && ctx_q[7] == '0 && ctx_q[16] == '0 && ctx_q[31] == '0);

    a_r4_fetch_has_request: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(stg_v[NSTG-1]) && !$past(rst));

endmodule

// File: rtl/exec_cmd_port.sv
`timescale 1ns/1ps
module exec_cmd_port
    import ecp_pkg::*;
#(
    parameter int IMEM_DEPTH = 256,
    parameter int DMEM_DEPTH = 256,
    parameter int RD_LAT     = 2,
    parameter int STEP_LAT   = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  bus_sel,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);

    localparam int IW  = $clog2(IMEM_DEPTH);
    localparam int DIW = $clog2(DMEM_DEPTH);
    localparam int AW0 = (IW > DIW) ? IW : DIW;
    localparam int AW  = (AW0 > CTX_IDX_W) ? AW0 : CTX_IDX_W;

    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] addr_q;
    logic              wr_data, wr_addr, wr_cmd, wr_watch;
    req_t              req;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              running, halted, flushed;
    logic [DATA_W-1:0] watch, profile;

    assign wr_data  = bus_wr && (bus_sel == SEL_DATA);
    assign wr_addr  = bus_wr && (bus_sel == SEL_ADDR);
    assign wr_cmd   = bus_wr && (bus_sel == SEL_CMD);
    assign wr_watch = bus_wr && (bus_sel == SEL_WATCH);

    ecp_decode u_decode (
        .strobe (wr_cmd),
        .code   (bus_wdata[7:0]),
        .req    (req)
    );

    ecp_run_ctrl #(
        .STEP_LAT (STEP_LAT)
    ) u_run (
        .clk         (clk),
        .rst         (rst),
        .op          (req.op),
        .watch_wr    (wr_watch),
        .watch_wdata (bus_wdata),
        .running     (running),
        .halted      (halted),
        .flushed     (flushed),
        .watch       (watch),
        .profile     (profile)
    );

    ecp_store #(
        .IMEM_DEPTH (IMEM_DEPTH),
        .DMEM_DEPTH (DMEM_DEPTH),
        .RD_LAT     (RD_LAT)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .addr     (addr_q[AW-1:0]),
        .wdata    (data_q),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst)
            data_q <= '0;
        else if (rd_valid)
            data_q <= rd_data;
        else if (wr_data)
            data_q <= bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (wr_addr)
            addr_q <= bus_wdata;
    end

    always_comb begin
        case (sel_e'(bus_sel))
            SEL_DATA:  bus_rdata = data_q;
            SEL_ADDR:  bus_rdata = addr_q;
            SEL_CMD:   bus_rdata = status_word(running, halted, flushed);
            SEL_WATCH: bus_rdata = watch;
            SEL_PROF:  bus_rdata = profile;
            default:   bus_rdata = '0;
        endcase
    end

    a_r4_data_source: assert property (@(posedge clk) disable iff (rst)
        (data_q != $past(data_q)) |-> $past(rd_valid || wr_data));

    a_r2_addr_host_only: assert property (@(posedge clk) disable iff (rst)
        (addr_q != $past(addr_q)) |-> $past(wr_addr));

    a_r5_run_halt_exclusive: assert property (@(posedge clk) disable iff (rst)
        $countones({running, halted}) == 1);

endmodule

// File: tb/test_exec_cmd_port.sv
`timescale 1ns/1ps
module test_exec_cmd_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_sel = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    exec_cmd_port i_exec_cmd_port (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic logic ctx_ok(input logic [31:0] a);
        logic [4:0] c;
        c = a[4:0];
        if (c == 5'h11) return 1'b1;
        if (c[4]) return 1'b0;
        return c[1:0] != 2'b11;
    endfunction

    function automatic logic [31:0] xfer_code(input int space, input logic store);
        return 32'h10 | (32'(space) << 1) | 32'(store);
    endfunction

    function automatic logic [31:0] fetch_expect(input int space, input logic [31:0] a,
                                                 input logic [31:0] v);
        if (space == 2 && !ctx_ok(a)) return 32'h0;
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] v);
        bus_sel   = s;
        bus_wdata = v;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] v);
        bus_sel = s;
        #1;
        v = bus_rdata;
        @(negedge clk);
    endtask

    task automatic store(input int space, input logic [31:0] a, input logic [31:0] v);
        wr(3'd0, v);
        wr(3'd1, a);
        wr(3'd2, xfer_code(space, 1'b1));
    endtask

    task automatic fetch(input string tag, input int space, input logic [31:0] a,
                         input logic [31:0] exp, input logic chk_stale);
        logic [31:0] prev, r0, r1, r2;
        rd(3'd0, prev);
        wr(3'd1, a);
        wr(3'd2, xfer_code(space, 1'b0));
        rd(3'd0, r0);
        rd(3'd0, r1);
        rd(3'd0, r2);
        if (chk_stale) begin
            check({"R4 stale first ", tag}, r0, prev);
            check({"R4 stale second ", tag}, r1, prev);
        end
        check(tag, r2, exp);
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, w0, p;
        logic [31:0] seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd2, v); check("R1 status", v, 32'h4000_0000);
        rd(3'd3, v); check("R1 watch", v, 0);
        rd(3'd4, v); check("R1 profile", v, 0);
        rd(3'd0, v); check("R1 data", v, 0);
        rd(3'd1, v); check("R1 addr", v, 0);

        // R2 host register map
        wr(3'd0, 32'hA5A5_0F0F); rd(3'd0, v); check("R2 data readback", v, 32'hA5A5_0F0F);
        wr(3'd1, 32'h1234_5678); rd(3'd1, v); check("R2 addr readback", v, 32'h1234_5678);
        rd(3'd5, v); check("R2 unused select", v, 0);
        rd(3'd7, v); check("R2 unused select 7", v, 0);

        // R3 / R4 stores and fetches, with stale-read timing
        store(0, 32'h0000_0005, 32'hDEAD_0001);
        store(1, 32'h0000_0040, 32'hBEEF_0002);
        fetch("R3 imem", 0, 32'h5, 32'hDEAD_0001, 1'b1);
        fetch("R3 dmem", 1, 32'h40, 32'hBEEF_0002, 1'b1);
        store(0, 32'h0000_0105, 32'hCAFE_0003);
        fetch("R3 imem wrap", 0, 32'h5, 32'hCAFE_0003, 1'b1);

        // R9 context holes and valid entries
        fetch("R9 ctx reset", 2, 32'h0E, 32'h0, 1'b1);
        store(2, 32'h03, 32'h1111_2222);
        fetch("R9 ctx hole", 2, 32'h03, 32'h0, 1'b0);
        store(2, 32'h10, 32'h3333_4444);
        fetch("R9 ctx hole 0x10", 2, 32'h10, 32'h0, 1'b0);
        store(2, 32'h11, 32'h5555_6666);
        fetch("R9 ctx instr reg", 2, 32'h11, 32'h5555_6666, 1'b1);
        store(2, 32'h0C, 32'h7777_8888);
        fetch("R9 ctx debug", 2, 32'h0C, 32'h7777_8888, 1'b1);

        // R5 start / halt, R2 upper command bits ignored
        wr(3'd2, 32'hFFFF_FF02); rd(3'd2, v); check("R5 start (R2 upper bits)", v, 32'h8000_0000);
        wr(3'd2, 32'h3); rd(3'd2, v); check("R5 halt", v, 32'h4000_0000);

        // R6 flush pulse
        wr(3'd2, 32'h4);
        rd(3'd2, v); check("R6 flush pulse", v, 32'h6080_0000);
        rd(3'd2, v); check("R6 flush ends", v, 32'h4000_0000);

        // R7 step timing
        rd(3'd3, w0);
        wr(3'd2, 32'h1);
        rd(3'd3, v); rd(3'd3, v);
        rd(3'd3, v); check("R7 step not yet", v, w0);
        rd(3'd3, v); check("R7 step done", v, w0 + 1);
        w0 = v;
        wr(3'd2, 32'h1);
        wr(3'd2, 32'h1);
        rd(3'd3, v); rd(3'd3, v);
        rd(3'd3, v); check("R7 first step lands", v, w0 + 1);
        rd(3'd3, v); check("R7 step in flight ignored", v, w0 + 1);
        w0 = v;
        wr(3'd2, 32'h2);
        wr(3'd2, 32'h1);
        repeat (5) rd(3'd3, v);
        check("R7 step while running ignored", v, w0);
        wr(3'd2, 32'h3);
        wr(3'd3, 32'd100); rd(3'd3, v); check("R2 watch writable", v, 100);

        // R8 profile counter
        wr(3'd2, 32'h0C); rd(3'd4, v); check("R8 clear halted", v, 0);
        wr(3'd2, 32'h2);
        rd(3'd4, v); check("R8 first running cycle", v, 0);
        rd(3'd4, v); check("R8 count 1", v, 1);
        rd(3'd4, v); check("R8 count 2", v, 2);
        wr(3'd2, 32'h0C);
        rd(3'd4, v); check("R8 clear wins", v, 0);
        rd(3'd4, v); check("R8 recount", v, 1);
        wr(3'd2, 32'h3);
        rd(3'd4, p);
        rd(3'd4, v); check("R8 frozen halted", v, p);
        wr(3'd4, 32'd55); rd(3'd4, v); check("R2 profile read-only", v, p);

        // R10 unknown codes
        rd(3'd3, w0);
        wr(3'd0, 32'h9999_0000);
        wr(3'd2, 32'h07);
        rd(3'd2, v); check("R10 code 07 status", v, 32'h4000_0000);
        wr(3'd2, 32'h16);
        rd(3'd0, v); rd(3'd0, v); rd(3'd0, v);
        check("R10 code 16 data kept", v, 32'h9999_0000);
        wr(3'd2, 32'h20);
        rd(3'd3, v); check("R10 watch kept", v, w0);
        rd(3'd4, v); check("R10 profile kept", v, p);

        // Random stores and fetches (R3, R4, R9)
        for (int it = 0; it < 80; it++) begin
            int sp;
            logic [31:0] a, d;
            sp = int'($urandom % 3);
            a  = $urandom % 32'h400;
            d  = $urandom;
            store(sp, a, d);
            fetch(sp == 2 ? "R9 random ctx" : "R3 random mem", sp, a,
                  fetch_expect(sp, a, d), 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule